// File: doc/BRIEF.md
# Bad-Block-Skipping Flash Image Loader

This block copies a contiguous image out of NAND flash into memory by driving a separate page-read engine. Software hands it a page-aligned byte offset into the flash, an image length in bytes and a destination base address, then pulses `start`. The loader works out which erase block and page the image begins in and which block it ends in. It then visits the blocks one at a time.

For each block the loader first asks the engine for the bad-block marker, which lives in the spare area of page 0. A bad block is skipped whole, and the end of the range moves out by one block. The image therefore still receives the number of good blocks its length implies. In a good block, every page from the current page index to the end of the block is requested. The destination address advances by one page after each page.

Only one request is ever in flight: a one-cycle `rd_req` is answered by a one-cycle `rd_done`. The flash bus timing, ECC and the memory write path belong to the engine and lie outside this block. Block size, page size and pages per block are powers of two, so all geometry reduces to bit slicing.

Top module: `nand_image_loader`

## Requirements
- R1: On `start`, the first block is offset / (PAGE_BYTES·PAGES_PER_BLOCK), the final block is (offset + length − 1) / (PAGE_BYTES·PAGES_PER_BLOCK), and the initial page index is (offset mod block size) / PAGE_BYTES.
- R2: Before any page of a block is requested, exactly one marker request is issued for that block with `rd_is_mark`=1, `rd_page`=0 and `rd_col` = (PAGE_BYTES + MARK_POS) in byte mode, or that value shifted right by one in word mode (BUS16=1). Page requests carry `rd_is_mark`=0.
- R3: In byte mode only `mark_data[7:0]` is judged: a value other than 0xFF marks the block bad, and the upper byte has no effect. In word mode, any `mark_data` other than 0xFFFF marks the block bad.
- R4: For a bad block no page request is issued, the loader moves to the next block, the final-block value grows by one and `bad_count` increments by one.
- R5: In a good block, pages are requested in ascending order from the current page index through page PAGES_PER_BLOCK−1. `rd_dst` equals `dst_base` for the first page of a run and grows by PAGE_BYTES after each completed page.
- R6: The page index returns to 0 only after a good block finishes. A bad block leaves it unchanged, so a mid-block start that lands on a bad block carries its page index into the next good block.
- R7: `rd_req` is high for single cycles only, and a new request is never raised before the previous one has received `rd_done`.
- R8: When the current block passes the final block, `done` pulses for one cycle and `busy` falls on the next cycle. A zero length gives `done` with no request at all.
- R9: After reset the loader is idle with `rd_req`, `busy`, `done` low and `bad_count` zero. Each `start` clears `bad_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load (sampled when idle) |
| img_offset | input | OFFS_W | Page-aligned flash byte offset of the image |
| img_len | input | OFFS_W | Image length in bytes |
| dst_base | input | ADDR_W | Destination address of the first page |
| rd_req | output | 1 | One-cycle read request to the engine |
| rd_is_mark | output | 1 | 1: marker read, 0: page read |
| rd_block | output | BLK_W | Block index of the request |
| rd_page | output | PG_W | Page index within the block |
| rd_col | output | COL_W | Column of the request (marker position or 0) |
| rd_dst | output | ADDR_W | Destination address for the page being read |
| rd_done | input | 1 | One-cycle completion from the engine |
| mark_data | input | 16 | Marker value, valid with `rd_done` of a marker read |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle pulse at the end of a load |
| bad_count | output | BLK_W | Bad blocks skipped in the current or last load |

## Verification
Two functions can coincide: the range extension caused by a bad marker, and the loop-exit comparison. Both act on the final-block value, and the extension raises that value just as the current block would otherwise have passed it. The bench provokes this by marking the final block of a range bad, and also two consecutive blocks bad, after a mid-block start. It judges the outcome by whether page requests continue into the following good block at the carried page index, and by whether `done` appears only after those pages. A premature `done`, a missing block or a reset page index each show up as a mismatch against the bench's own model of the request stream.

// File: rtl/nil_pkg.sv
package nil_pkg;

  typedef enum logic [2:0] {
    LD_IDLE  = 3'd0,
    LD_CHECK = 3'd1,
    LD_MREQ  = 3'd2,
    LD_MWAIT = 3'd3,
    LD_PREQ  = 3'd4,
    LD_PWAIT = 3'd5,
    LD_FIN   = 3'd6
  } ld_state_t;

endpackage

// File: rtl/nil_geom.sv
module nil_geom #(
  parameter int OFFS_W = 32,
  parameter int PG_SH  = 11,
  parameter int BLK_SH = 17,
  localparam int PG_W  = BLK_SH - PG_SH,
  localparam int BLK_W = OFFS_W + 1 - BLK_SH
) (
  input  logic [OFFS_W-1:0] offs,
  input  logic [OFFS_W-1:0] len,
  output logic [BLK_W-1:0]  first_blk,
  output logic [BLK_W-1:0]  last_blk,
  output logic [PG_W-1:0]   first_pg,
  output logic              empty
);

  function automatic logic [BLK_W-1:0] blk_of(input logic [OFFS_W:0] byte_pos);
    return byte_pos[OFFS_W:BLK_SH];
  endfunction

  function automatic logic [PG_W-1:0] pg_of(input logic [OFFS_W-1:0] byte_pos);
    return byte_pos[BLK_SH-1:PG_SH];
  endfunction

  logic [OFFS_W:0] end_pos;

  always_comb begin
    end_pos   = {1'b0, offs} + {1'b0, len} - {{OFFS_W{1'b0}}, 1'b1};
    first_blk = blk_of({1'b0, offs});
    last_blk  = blk_of(end_pos);
    first_pg  = pg_of(offs);
    empty     = (len == '0);
  end

endmodule

// File: rtl/nil_mark_judge.sv
module nil_mark_judge #(
  parameter bit BUS16 = 1'b0
) (
  input  logic [15:0] mark_data,
  output logic        is_bad
);

  generate
    if (BUS16) begin : g_word
      assign is_bad = (mark_data != 16'hFFFF);
    end else begin : g_byte
      assign is_bad = (mark_data[7:0] != 8'hFF);
    end
  endgenerate

endmodule

// File: rtl/nand_image_loader.sv
module nand_image_loader
  import nil_pkg::*;
#(
  parameter int OFFS_W          = 32,
  parameter int ADDR_W          = 32,
  parameter int PAGE_BYTES      = 2048,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int MARK_POS        = 0,
  parameter bit BUS16           = 1'b0,
  localparam int PG_SH    = $clog2(PAGE_BYTES),
  localparam int PG_W     = $clog2(PAGES_PER_BLOCK),
  localparam int BLK_SH   = PG_SH + PG_W,
  localparam int BLK_W    = OFFS_W + 1 - BLK_SH,
  localparam int COL_W    = PG_SH + 2,
  localparam int MARK_COL = (PAGE_BYTES + MARK_POS) >> (BUS16 ? 1 : 0)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OFFS_W-1:0] img_offset,
  input  logic [OFFS_W-1:0] img_len,
  input  logic [ADDR_W-1:0] dst_base,
  output logic              rd_req,
  output logic              rd_is_mark,
  output logic [BLK_W-1:0]  rd_block,
  output logic [PG_W-1:0]   rd_page,
  output logic [COL_W-1:0]  rd_col,
  output logic [ADDR_W-1:0] rd_dst,
  input  logic              rd_done,
  input  logic [15:0]       mark_data,
  output logic              busy,
  output logic              done,
  output logic [BLK_W-1:0]  bad_count
);

  localparam logic [PG_W-1:0] LAST_PG = PG_W'(PAGES_PER_BLOCK - 1);

  ld_state_t         state;
  logic [BLK_W-1:0]  cur_blk, end_blk, bad_cnt;
  logic [PG_W-1:0]   cur_pg;
  logic [ADDR_W-1:0] dst;

  logic [BLK_W-1:0]  g_first, g_last;
  logic [PG_W-1:0]   g_pg;
  logic              g_empty;
  logic              blk_bad;

  // named internal events, also watched by the checker
  logic ev_bad, ev_good, ev_page, ev_blk_end, in_range;

  nil_geom #(
    .OFFS_W (OFFS_W),
    .PG_SH  (PG_SH),
    .BLK_SH (BLK_SH)
  ) u_geom (
    .offs      (img_offset),
    .len       (img_len),
    .first_blk (g_first),
    .last_blk  (g_last),
    .first_pg  (g_pg),
    .empty     (g_empty)
  );

  nil_mark_judge #(.BUS16(BUS16)) u_judge (
    .mark_data (mark_data),
    .is_bad    (blk_bad)
  );

  assign ev_bad     = (state == LD_MWAIT) && rd_done && blk_bad;
  assign ev_good    = (state == LD_MWAIT) && rd_done && !blk_bad;
  assign ev_page    = (state == LD_PWAIT) && rd_done;
  assign ev_blk_end = ev_page && (cur_pg == LAST_PG);
  assign in_range   = (cur_blk <= end_blk);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= LD_IDLE;
      cur_blk <= '0;
      end_blk <= '0;
      bad_cnt <= '0;
      cur_pg  <= '0;
      dst     <= '0;
    end else begin
      case (state)
        LD_IDLE: begin
          if (start) begin
            cur_blk <= g_first;
            end_blk <= g_last;
            cur_pg  <= g_pg;
            dst     <= dst_base;
            bad_cnt <= '0;
            state   <= g_empty ? LD_FIN : LD_CHECK;
          end
        end
        LD_CHECK: state <= in_range ? LD_MREQ : LD_FIN;
        LD_MREQ:  state <= LD_MWAIT;
        LD_MWAIT: begin
          if (ev_bad) begin
            bad_cnt <= bad_cnt + BLK_W'(1);
            end_blk <= end_blk + BLK_W'(1);
            cur_blk <= cur_blk + BLK_W'(1);
            state   <= LD_CHECK;
          end else if (ev_good) begin
            state   <= LD_PREQ;
          end
        end
        LD_PREQ:  state <= LD_PWAIT;
        LD_PWAIT: begin
          if (ev_page) begin
            dst <= dst + ADDR_W'(PAGE_BYTES);
            if (ev_blk_end) begin
              cur_pg  <= '0;
              cur_blk <= cur_blk + BLK_W'(1);
              state   <= LD_CHECK;
            end else begin
              cur_pg  <= cur_pg + PG_W'(1);
              state   <= LD_PREQ;
            end
          end
        end
        LD_FIN:   state <= LD_IDLE;
        default:  state <= LD_IDLE;
      endcase
    end
  end

  assign rd_req     = (state == LD_MREQ) || (state == LD_PREQ);
  assign rd_is_mark = (state == LD_MREQ) || (state == LD_MWAIT);
  assign rd_block   = cur_blk;
  assign rd_page    = rd_is_mark ? '0 : cur_pg;
  assign rd_col     = rd_is_mark ? COL_W'(MARK_COL) : '0;
  assign rd_dst     = dst;
  assign busy       = (state != LD_IDLE);
  assign done       = (state == LD_FIN);
  assign bad_count  = bad_cnt;

endmodule

// File: rtl/nil_checker.sv
module nil_checker #(
  parameter int ADDR_W     = 32,
  parameter int BLK_W      = 16,
  parameter int PG_W       = 6,
  parameter int COL_W      = 13,
  parameter int PAGE_BYTES = 2048,
  parameter int MARK_COL   = 2048
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic              rd_is_mark,
  input logic              rd_done,
  input logic [PG_W-1:0]   rd_page,
  input logic [COL_W-1:0]  rd_col,
  input logic [BLK_W-1:0]  rd_block,
  input logic [ADDR_W-1:0] rd_dst,
  input logic              done,
  input logic              busy,
  input logic [BLK_W-1:0]  bad_count,
  input logic              ev_bad,
  input logic              ev_page
);

  logic pend;

  always_ff @(posedge clk) begin
    if (!rst_n)       pend <= 1'b0;
    else if (rd_req)  pend <= 1'b1;
    else if (rd_done) pend <= 1'b0;
  end

  AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rst_n) rd_req |-> !pend); // R7
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rd_req |=> !rd_req); // R7
  AST_MARK_SPOT: assert property (@(posedge clk) disable iff (!rst_n) (rd_req && rd_is_mark) |-> (rd_page == '0 && rd_col == COL_W'(MARK_COL))); // R2
  AST_BAD_SKIP: assert property (@(posedge clk) disable iff (!rst_n) ev_bad |=> (bad_count == $past(bad_count) + BLK_W'(1) && rd_block == $past(rd_block) + BLK_W'(1))); // R4
  AST_BAD_NO_PAGE: assert property (@(posedge clk) disable iff (!rst_n) ev_bad |=> !rd_req); // R4
  AST_DST_STEP: assert property (@(posedge clk) disable iff (!rst_n) ev_page |=> rd_dst == $past(rd_dst) + ADDR_W'(PAGE_BYTES)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> (!done && !busy)); // R8

endmodule

bind nand_image_loader nil_checker #(
  .ADDR_W     (ADDR_W),
  .BLK_W      (BLK_W),
  .PG_W       (PG_W),
  .COL_W      (COL_W),
  .PAGE_BYTES (PAGE_BYTES),
  .MARK_COL   (MARK_COL)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_req     (rd_req),
  .rd_is_mark (rd_is_mark),
  .rd_done    (rd_done),
  .rd_page    (rd_page),
  .rd_col     (rd_col),
  .rd_block   (rd_block),
  .rd_dst     (rd_dst),
  .done       (done),
  .busy       (busy),
  .bad_count  (bad_count),
  .ev_bad     (ev_bad),
  .ev_page    (ev_page)
);

// File: tb/sim_nand_image_loader.sv
module sim_nand_image_loader;

  localparam int CLK_PERIOD = 10;
  localparam int OW  = 16;
  localparam int AW  = 16;
  localparam int PB  = 16;
  localparam int PPB = 4;
  localparam int BS  = PB * PPB;
  localparam int BW  = OW + 1 - 6;
  localparam int PW  = 2;
  localparam int CW  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // byte-mode instance
  logic          start0 = 1'b0;
  logic [OW-1:0] offs0 = '0, len0 = '0;
  logic [AW-1:0] base0 = '0;
  logic          rd_req0, rd_is_mark0, busy0, done0;
  logic [BW-1:0] rd_block0, bad_count0;
  logic [PW-1:0] rd_page0;
  logic [CW-1:0] rd_col0;
  logic [AW-1:0] rd_dst0;
  logic          rd_done0 = 1'b0;
  logic [15:0]   mark0 = 16'h0000;

  nand_image_loader #(
    .OFFS_W(OW), .ADDR_W(AW), .PAGE_BYTES(PB), .PAGES_PER_BLOCK(PPB),
    .MARK_POS(5), .BUS16(1'b0)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start0), .img_offset(offs0), .img_len(len0),
    .dst_base(base0), .rd_req(rd_req0), .rd_is_mark(rd_is_mark0), .rd_block(rd_block0),
    .rd_page(rd_page0), .rd_col(rd_col0), .rd_dst(rd_dst0), .rd_done(rd_done0),
    .mark_data(mark0), .busy(busy0), .done(done0), .bad_count(bad_count0)
  );

  // word-mode instance
  logic          start1 = 1'b0;
  logic          rd_req1, rd_is_mark1, busy1, done1;
  logic [BW-1:0] rd_block1, bad_count1;
  logic [PW-1:0] rd_page1;
  logic [CW-1:0] rd_col1;
  logic [AW-1:0] rd_dst1;
  logic          rd_done1 = 1'b0;
  logic [15:0]   mark1 = 16'h0000;

  nand_image_loader #(
    .OFFS_W(OW), .ADDR_W(AW), .PAGE_BYTES(PB), .PAGES_PER_BLOCK(PPB),
    .MARK_POS(0), .BUS16(1'b1)
  ) u1 (
    .clk(clk), .rst_n(rst_n), .start(start1), .img_offset(16'd0), .img_len(16'd64),
    .dst_base(16'h0200), .rd_req(rd_req1), .rd_is_mark(rd_is_mark1), .rd_block(rd_block1),
    .rd_page(rd_page1), .rd_col(rd_col1), .rd_dst(rd_dst1), .rd_done(rd_done1),
    .mark_data(mark1), .busy(busy1), .done(done1), .bad_count(bad_count1)
  );

  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // engine model for u0
  logic [63:0] badmask = '0;
  int pg_n = 0, mk_n = 0, col_err = 0;
  int lg_blk[64], lg_pg[64], lg_dst[64];

  initial begin
    int cnt = 0;
    int hold_blk = 0;
    forever begin
      @(negedge clk);
      rd_done0 = 1'b0;
      if (rd_req0) begin
        hold_blk = int'(rd_block0);
        if (rd_is_mark0) begin
          mk_n++;
          if (rd_col0 != CW'(21) || rd_page0 != '0) col_err++;
        end else if (pg_n < 64) begin
          lg_blk[pg_n] = int'(rd_block0);
          lg_pg[pg_n]  = int'(rd_page0);
          lg_dst[pg_n] = int'(rd_dst0);
          pg_n++;
        end
        cnt = 1 + (hold_blk % 3);
      end else if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          rd_done0 = 1'b1;
          if (hold_blk < 64 && badmask[hold_blk])
            mark0 = hold_blk[0] ? 16'hFFFE : 16'hFF00;
          else
            mark0 = 16'h00FF;
        end
      end
    end
  end

  // engine model for u1
  int pg1_n = 0, first_blk1 = -1, col1 = -1;
  initial begin
    int cnt = 0;
    int hb = 0;
    forever begin
      @(negedge clk);
      rd_done1 = 1'b0;
      if (rd_req1) begin
        hb = int'(rd_block1);
        if (rd_is_mark1) col1 = int'(rd_col1);
        else begin
          if (pg1_n == 0) first_blk1 = hb;
          pg1_n++;
        end
        cnt = 1;
      end else if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          rd_done1 = 1'b1;
          mark1 = (hb == 0) ? 16'h00FF : 16'hFFFF;
        end
      end
    end
  end

  task automatic run_case(input string name, input int offs, input int len,
                          input int base, input logic [63:0] bm);
    int e_blk[64], e_pg[64];
    int n = 0, visits = 0, nbad = 0;
    int t = 0;
    badmask = bm;
    pg_n = 0; mk_n = 0; col_err = 0;
    if (len > 0) begin
      int b = offs / BS;
      int last = (offs + len - 1) / BS;
      int p = (offs % BS) / PB;
      while (b <= last) begin
        visits++;
        if (bm[b]) begin
          nbad++;
          last++;
        end else begin
          for (int q = p; q < PPB; q++) begin
            e_blk[n] = b; e_pg[n] = q; n++;
          end
          p = 0;
        end
        b++;
      end
    end
    @(negedge clk);
    offs0 = OW'(offs); len0 = OW'(len); base0 = AW'(base); start0 = 1'b1;
    @(negedge clk);
    start0 = 1'b0;
    while (!done0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk("R8", {name, " done pulse seen"}, int'(done0), 1);
    @(negedge clk);
    chk("R8", {name, " busy low after done"}, int'(busy0), 0);
    chk("R5", {name, " page request count"}, pg_n, n);
    chk("R2", {name, " marker request count"}, mk_n, visits);
    chk("R2", {name, " marker page/column errors"}, col_err, 0);
    chk("R4", {name, " bad_count"}, int'(bad_count0), nbad);
    for (int i = 0; i < n && i < pg_n; i++) begin
      chk("R1", {name, " page block"}, lg_blk[i], e_blk[i]);
      chk("R6", {name, " page index"}, lg_pg[i], e_pg[i]);
      chk("R5", {name, " page dst"}, lg_dst[i], (base + i * PB) & 16'hFFFF);
    end
  endtask

  task automatic t_reset;
    chk("R9", "rd_req after reset", int'(rd_req0), 0);
    chk("R9", "busy after reset", int'(busy0), 0);
    chk("R9", "done after reset", int'(done0), 0);
    chk("R9", "bad_count after reset", int'(bad_count0), 0);
  endtask

  task automatic t_aligned;   // R1 R5, good markers carry 0x00 upper byte (R3)
    run_case("aligned", 0, 128, 16'h1000, 64'h0);
  endtask

  task automatic t_mid_start; // R1 R6 partial first block, later blocks from page 0
    run_case("midstart", 32, 100, 16'h2000, 64'h0);
  endtask

  task automatic t_bad_mid;   // R4 bad block inside range extends the end
    run_case("badmid", 64, 128, 16'h3000, 64'h4);
    chk("R3", "bad block 2 skipped (low byte 0x00)", int'(bad_count0), 1);
  endtask

  task automatic t_bad_carry; // R6 R4 consecutive bad blocks at the final block, page carried
    run_case("badcarry", 16, 48, 16'h4000, 64'h3);
  endtask

  task automatic t_empty;     // R8 zero length
    run_case("empty", 128, 0, 16'h5000, 64'h0);
    chk("R9", "bad_count cleared by new start", int'(bad_count0), 0);
  endtask

  task automatic t_word_mode; // R3 word-mode marker 0x00FF is bad; R2 column halved
    int t = 0;
    @(negedge clk);
    start1 = 1'b1;
    @(negedge clk);
    start1 = 1'b0;
    while (!done1 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk("R8", "word mode done", int'(done1), 1);
    chk("R3", "word mode bad_count", int'(bad_count1), 1);
    chk("R3", "word mode first page block", first_blk1, 1);
    chk("R4", "word mode page count", pg1_n, PPB);
    chk("R2", "word mode marker column", col1, 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_aligned();
    t_mid_start();
    t_bad_mid();
    t_bad_carry();
    t_empty();
    t_word_mode();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

endmodule